// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial frames from a single RX line. A tick at sixteen times the bit rate drives a sampler. The sampler finds the falling edge of a start bit, rejects glitches, and settles each bit by a two-of-three vote over the middle samples of the bit. Frames carry 8 or 9 data bits, least significant bit first, between one start bit and one stop bit. The last data bit can serve as a parity bit. Each completed frame is copied to a data register and a data-ready flag is raised. Framing and parity errors are flagged as well.

A counter tracks how many consecutive bits have been decided as zero. When break detection is turned on, this counter separates two cases. A line that goes low at the start bit and stays low for a whole frame is a break: no byte is delivered and no error is raised. A line that drops partway through a frame ends in a delivered byte with a framing error, and a break is reported later, once the run of zeros is long enough. After a break, the receiver stays deaf to start bits until it has decided a high bit. All flags are sticky and are cleared by per-flag strobes.

Top module: `uart_brk_rx`

## Requirements
- R1: In idle, a tick with `rx_i` low starts a frame. If the vote on the start bit reads high, the frame is dropped, no flag changes, and the receiver returns to idle.
- R2: A bit lasts 16 ticks, and the tick that detects the start is sample 1. Each bit value is the majority of samples 7, 8 and 9 of that bit.
- R3: `nine_bit_i`=0 selects 8 data bits and `nine_bit_i`=1 selects 9 data bits, sent LSB first. The received bits appear on `rx_data_o` bit 0 upward. `rx_data_o[8]` is 0 for 8-bit frames.
- R4: A frame whose stop bit reads high loads `rx_data_o` and sets `rdf_o` in the cycle after the stop-bit vote. `fe_o` does not change.
- R5: With `par_en_i`=1, the last data bit is the parity bit. `pe_o` is set on load when the XOR of all received data bits differs from `par_odd_i` (0 selects even parity, 1 selects odd parity).
- R6: With `brk_en_i`=0, a stop bit that reads low still loads the data and sets `rdf_o` and `fe_o`, with `pe_o` set as in R5. The receiver then returns to idle.
- R7: With `brk_en_i`=1, a frame whose every bit reads low (10 bits for 8-bit frames, 11 bits for 9-bit frames) loads nothing. `rx_data_o`, `rdf_o`, `fe_o` and `pe_o` keep their values, and `brk_o` is set at the stop-bit vote.
- R8: With `brk_en_i`=1, if the zeros begin after the start bit, the frame loads the bits received so far and sets `rdf_o` and `fe_o`, with `pe_o` set as in R5. `brk_o` is set when the run of zeros reaches the frame length.
- R9: Any bit that reads high resets the zero-run count. The count holds at the frame length, so a break that continues after `brk_o` is cleared does not set it again.
- R10: After a break or a framing error with `brk_en_i`=1, no start bit is searched for until a bit reads high.
- R11: Each flag stays set until its clear strobe arrives. A set and a clear in the same cycle leave the flag set.
- R12: During and after reset, `rx_data_o` and all four flags are 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_i | input | 1 | Serial receive line, synchronous to clk_i |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en_i | input | 1 | Last data bit is checked as parity |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| brk_en_i | input | 1 | Enables break detection |
| clr_rdf_i | input | 1 | Clears the data-ready flag |
| clr_fe_i | input | 1 | Clears the framing-error flag |
| clr_pe_i | input | 1 | Clears the parity-error flag |
| clr_brk_i | input | 1 | Clears the break flag |
| rx_data_o | output | 9 | Last loaded frame data |
| rdf_o | output | 1 | Data-ready flag |
| fe_o | output | 1 | Framing-error flag |
| pe_o | output | 1 | Parity-error flag |
| brk_o | output | 1 | Break-detected flag |

## Verification
A sampling phase that is off by even one tick shifts the vote window. Data or false-start decisions then go wrong, and this shows on `rx_data_o` or `rdf_o` within the same frame. A zero-run count that drifts shows in two ways. An aligned break may be delivered as a zero byte with a framing error at the stop bit. Or `brk_o` may rise one bit too early or too late, or rise a second time during a long low line. A receiver that leaves its hold state too early restarts frames on a low line and re-raises `brk_o` within about one frame time.

// File: rtl/uart_brk_pkg.sv
`timescale 1ns/1ps
package uart_brk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} rx_state_e;

  localparam int unsigned FLAG_N = 4;
  localparam int unsigned F_RDF  = 0;
  localparam int unsigned F_FE   = 1;
  localparam int unsigned F_PE   = 2;
  localparam int unsigned F_BRK  = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_bit_sampler.sv
`timescale 1ns/1ps
module uart_bit_sampler import uart_brk_pkg::*; #(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic start_i,
  input  logic active_i,
  output logic dec_o,
  output logic val_o,
  output logic wrap_o
);
  localparam int unsigned PW = $clog2(OSR);
  localparam logic [PW-1:0] MID  = PW'(OSR / 2);
  localparam logic [PW-1:0] SMP0 = PW'(OSR / 2 - 2);
  localparam logic [PW-1:0] SMP1 = PW'(OSR / 2 - 1);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);

  logic [PW-1:0] phase_q;
  logic          s0_q, s1_q;

  // detect tick is sample 1, so phase counts samples already taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      s0_q    <= 1'b1;
      s1_q    <= 1'b1;
    end else if (tick_i) begin
      if (start_i) begin
        phase_q <= PW'(1);
      end else if (active_i) begin
        if (phase_q == SMP0) s0_q <= rx_i;
        if (phase_q == SMP1) s1_q <= rx_i;
        phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
    end
  end

  assign dec_o  = tick_i & active_i & (phase_q == MID);
  assign val_o  = maj3(s0_q, s1_q, rx_i);
  assign wrap_o = tick_i & active_i & (phase_q == LAST);

  // R2: vote happens once, at the middle sample, then phase moves on
  a_r2_mid_vote: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o |=> (phase_q == MID + PW'(1)));
endmodule

// File: rtl/uart_zero_cnt.sv
`timescale 1ns/1ps
module uart_zero_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          dec_i,
  input  logic          val_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clr_i)                        cnt_q <= '0;
    else if (dec_i && val_i)               cnt_q <= '0;
    else if (dec_i && cnt_q != limit_i)    cnt_q <= cnt_q + 1'b1;
  end

  // this zero completes a full frame of zeros
  assign hit_o = dec_i & ~val_i & (cnt_q == limit_i - 1'b1);

  a_r9_one_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && val_i) |=> (cnt_q == '0));
  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !val_i && !clr_i && cnt_q == limit_i && $stable(limit_i)) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/uart_sticky_flag.sv
`timescale 1ns/1ps
module uart_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/uart_brk_rx.sv
`timescale 1ns/1ps
module uart_brk_rx import uart_brk_pkg::*; #(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          rx_i,
  input  logic          nine_bit_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          brk_en_i,
  input  logic          clr_rdf_i,
  input  logic          clr_fe_i,
  input  logic          clr_pe_i,
  input  logic          clr_brk_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rdf_o,
  output logic          fe_o,
  output logic          pe_o,
  output logic          brk_o
);
  localparam int unsigned IW = $clog2(DW + 2);
  localparam int unsigned CW = $clog2(DW + 3);

  rx_state_e         st_q, st_d;
  logic [IW-1:0]     bit_q, n_data;
  logic [CW-1:0]     limit;
  logic [DW-1:0]     data_q, data_d;
  logic              start, active, dec, val, wrap, zc_hit, stop_bit;
  logic              load, set_fe, set_brk, par_bad;
  logic [FLAG_N-1:0] f_set, f_clr, f_q;

  assign n_data   = nine_bit_i ? IW'(DW) : IW'(DW - 1);
  assign limit    = CW'(n_data) + CW'(2);
  assign start    = tick16_i & (st_q == ST_IDLE) & ~rx_i;
  assign active   = (st_q != ST_IDLE);
  assign stop_bit = (bit_q == n_data + IW'(1));
  assign par_bad  = par_en_i & ((^data_q) ^ par_odd_i);

  uart_bit_sampler #(.OSR(OSR)) u_sampler (
    .clk_i, .rst_ni, .tick_i(tick16_i), .rx_i, .start_i(start),
    .active_i(active), .dec_o(dec), .val_o(val), .wrap_o(wrap)
  );

  uart_zero_cnt #(.CW(CW)) u_zero_cnt (
    .clk_i, .rst_ni, .clr_i(start), .dec_i(dec), .val_i(val),
    .limit_i(limit), .hit_o(zc_hit)
  );

  always_comb begin
    st_d    = st_q;
    load    = 1'b0;
    set_fe  = 1'b0;
    set_brk = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_RUN;
      ST_RUN: if (dec) begin
        if (bit_q == '0) begin
          if (val) st_d = ST_IDLE;             // false start
        end else if (stop_bit) begin
          if (val) begin
            load = 1'b1;
            st_d = ST_IDLE;
          end else if (brk_en_i && zc_hit) begin
            set_brk = 1'b1;                    // break aligned to start bit
            st_d    = ST_HOLD;
          end else begin
            load   = 1'b1;
            set_fe = 1'b1;
            st_d   = brk_en_i ? ST_HOLD : ST_IDLE;
          end
        end
      end
      ST_HOLD: if (dec) begin
        if (val)                   st_d = ST_IDLE;
        else if (brk_en_i && zc_hit) set_brk = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    data_d = data_q;
    if (start) begin
      data_d = '0;
    end else if (st_q == ST_RUN && dec && !stop_bit) begin
      for (int i = 0; i < DW; i++)
        if (bit_q == IW'(i + 1)) data_d[i] = val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      data_q    <= '0;
      rx_data_o <= '0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
      if (start)                        bit_q <= '0;
      else if (wrap && st_q == ST_RUN)  bit_q <= bit_q + 1'b1;
      if (load)                         rx_data_o <= data_q;
    end
  end

  assign f_set[F_RDF] = load;
  assign f_set[F_FE]  = set_fe;
  assign f_set[F_PE]  = load & par_bad;
  assign f_set[F_BRK] = set_brk;
  assign f_clr[F_RDF] = clr_rdf_i;
  assign f_clr[F_FE]  = clr_fe_i;
  assign f_clr[F_PE]  = clr_pe_i;
  assign f_clr[F_BRK] = clr_brk_i;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    uart_sticky_flag u_flag (
      .clk_i, .rst_ni, .set_i(f_set[g]), .clr_i(f_clr[g]), .q_o(f_q[g])
    );
  end

  assign rdf_o = f_q[F_RDF];
  assign fe_o  = f_q[F_FE];
  assign pe_o  = f_q[F_PE];
  assign brk_o = f_q[F_BRK];

  a_r1_false_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && bit_q == '0 && dec && val) |=> (st_q == ST_IDLE && !$rose(rdf_o)));
  a_r7_aligned_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && dec && stop_bit && !val && brk_en_i && zc_hit)
    |=> ($stable(rx_data_o) && brk_o && !$rose(fe_o) && !$rose(pe_o)));
  a_r8_mid_frame_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && dec && stop_bit && !val && !(brk_en_i && zc_hit)) |=> (rdf_o && fe_o));
  a_r10_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && dec && !val) |=> (st_q == ST_HOLD));
endmodule

// File: tb/uart_brk_rx_bench.sv
`timescale 1ns/1ps
module uart_brk_rx_bench;
  localparam int BT = 64;  // clocks per bit: 16 ticks of 4 clocks

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic nine = 1'b0, par_en = 1'b0, par_odd = 1'b0, brk_en = 1'b0;
  logic clr_rdf = 1'b0, clr_fe = 1'b0, clr_pe = 1'b0, clr_brk = 1'b0;
  logic [8:0] rx_data;
  logic rdf, fe, pe, brk;

  uart_brk_rx u_uart_brk_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx),
    .nine_bit_i(nine), .par_en_i(par_en), .par_odd_i(par_odd), .brk_en_i(brk_en),
    .clr_rdf_i(clr_rdf), .clr_fe_i(clr_fe), .clr_pe_i(clr_pe), .clr_brk_i(clr_brk),
    .rx_data_o(rx_data), .rdf_o(rdf), .fe_o(fe), .pe_o(pe), .brk_o(brk)
  );

  int n_chk = 0, n_err = 0, cyc = 0, tcnt = 0;
  bit cmp_en = 0, mon_en = 0, seen = 0, done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick generator and watchdog
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 3);
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // behavioural reference model
  int m_st = 0, m_ph = 0, m_bit = 0, m_zc = 0;
  bit m_a = 1, m_b = 1;
  logic [8:0] m_dat = '0, m_q = '0;
  bit m_rdf = 0, m_fe = 0, m_pe = 0, m_brk = 0;

  always @(posedge clk) begin
    int n, lim;
    bit v, s_rdf, s_fe, s_pe, s_brk;
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_bit = 0; m_zc = 0; m_a = 1; m_b = 1;
      m_dat = '0; m_q = '0; m_rdf = 0; m_fe = 0; m_pe = 0; m_brk = 0;
    end else begin
      n = nine ? 9 : 8;
      lim = n + 2;
      s_rdf = 0; s_fe = 0; s_pe = 0; s_brk = 0;
      if (tick) begin
        if (m_st == 0) begin
          if (!rx) begin m_st = 1; m_ph = 1; m_bit = 0; m_zc = 0; m_dat = '0; end
        end else begin
          if (m_ph == 6) m_a = rx;
          else if (m_ph == 7) m_b = rx;
          else if (m_ph == 8) begin
            v = (int'(m_a) + int'(m_b) + int'(rx)) >= 2;
            if (m_st == 1) begin
              if (m_bit == 0) begin
                if (v) m_st = 0;
              end else if (m_bit <= n) begin
                m_dat[m_bit-1] = v;
              end else begin
                if (v) s_rdf = 1;
                else if (brk_en && m_zc == lim - 1) begin s_brk = 1; m_st = 2; end
                else begin s_rdf = 1; s_fe = 1; end
                if (s_rdf) begin
                  m_q = m_dat;
                  s_pe = par_en && ((^m_dat) != par_odd);
                  m_st = (!v && brk_en) ? 2 : 0;
                end
              end
            end else begin
              if (v) m_st = 0;
              else if (brk_en && m_zc == lim - 1) s_brk = 1;
            end
            if (v) m_zc = 0;
            else if (m_zc < lim) m_zc++;
          end
          if (m_ph == 15) begin m_ph = 0; m_bit++; end
          else m_ph++;
        end
      end
      m_rdf = s_rdf | (m_rdf & !clr_rdf);
      m_fe  = s_fe  | (m_fe  & !clr_fe);
      m_pe  = s_pe  | (m_pe  & !clr_pe);
      m_brk = s_brk | (m_brk & !clr_brk);
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3 model data", int'(rx_data), int'(m_q));
      chk("R4 model rdf", int'(rdf), int'(m_rdf));
      chk("R6 model fe", int'(fe), int'(m_fe));
      chk("R5 model pe", int'(pe), int'(m_pe));
      chk("R7 model brk", int'(brk), int'(m_brk));
    end
    if (mon_en && rdf) seen = 1;
  end

  task automatic drive(input logic b, input int nclk);
    rx = b;
    repeat (nclk) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] val, input int nd);
    drive(1'b0, BT);
    for (int i = 0; i < nd; i++) drive(val[i], BT);
    drive(1'b1, BT);
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    {clr_brk, clr_pe, clr_fe, clr_rdf} = m;
    @(negedge clk);
    {clr_brk, clr_pe, clr_fe, clr_rdf} = 4'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R12 data in reset", int'(rx_data), 0);
    chk("R12 rdf in reset", int'(rdf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1;
    chk("R12 fe after reset", int'(fe), 0);
    chk("R12 pe after reset", int'(pe), 0);
    chk("R12 brk after reset", int'(brk), 0);
    drive(1'b1, BT);

    // 8-bit normal frame
    send_frame(9'h0A5, 8);
    chk("R2 R4 data 0xA5", int'(rx_data), 'h0A5);
    chk("R4 rdf set", int'(rdf), 1);
    chk("R4 fe clear", int'(fe), 0);
    drive(1'b1, 3 * BT);
    chk("R11 rdf sticky", int'(rdf), 1);
    pulse_clr(4'b0001);
    chk("R11 rdf cleared", int'(rdf), 0);

    // 9-bit frame
    nine = 1'b1;
    send_frame(9'h1C3, 9);
    chk("R3 nine-bit data", int'(rx_data), 'h1C3);
    pulse_clr(4'b0001);
    nine = 1'b0;

    // parity even, then odd
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(9'h0B5, 8);
    chk("R5 even parity error", int'(pe), 1);
    chk("R3 eight-bit data msb zero", int'(rx_data), 'h0B5);
    pulse_clr(4'b0101);
    par_odd = 1'b1;
    send_frame(9'h0B5, 8);
    chk("R5 odd parity ok", int'(pe), 0);
    pulse_clr(4'b0001);
    par_en = 1'b0; par_odd = 1'b0;

    // false start glitch
    drive(1'b0, 16);
    drive(1'b1, 2 * BT);
    chk("R1 glitch no rdf", int'(rdf), 0);
    chk("R1 glitch no fe", int'(fe), 0);
    send_frame(9'h03C, 8);
    chk("R1 frame after glitch", int'(rx_data), 'h03C);
    pulse_clr(4'b0001);

    // all-zero frame, break detection off
    drive(1'b0, 9 * BT + 48);
    drive(1'b1, 2 * BT);
    chk("R6 zero data", int'(rx_data), 0);
    chk("R6 rdf", int'(rdf), 1);
    chk("R6 fe", int'(fe), 1);
    chk("R6 no brk", int'(brk), 0);
    pulse_clr(4'b0011);

    // aligned break, break detection on
    brk_en = 1'b1;
    send_frame(9'h05A, 8);
    chk("R4 data before break", int'(rx_data), 'h05A);
    pulse_clr(4'b0001);
    par_en = 1'b1; par_odd = 1'b1;
    drive(1'b0, 10 * BT + 16);
    chk("R7 data kept", int'(rx_data), 'h05A);
    chk("R7 rdf unchanged", int'(rdf), 0);
    chk("R7 no fe", int'(fe), 0);
    chk("R7 no pe", int'(pe), 0);
    chk("R7 brk set", int'(brk), 1);
    pulse_clr(4'b1000);
    drive(1'b0, 20 * BT);
    chk("R9 brk not re-set", int'(brk), 0);
    chk("R10 no frame while low", int'(rdf), 0);
    par_en = 1'b0; par_odd = 1'b0;
    drive(1'b1, BT + BT / 2);
    send_frame(9'h096, 8);
    chk("R10 receives after high bit", int'(rx_data), 'h096);
    pulse_clr(4'b0001);

    // mid-frame break, even parity
    par_en = 1'b1;
    drive(1'b0, BT);
    drive(1'b1, BT);
    drive(1'b0, 8 * BT + 16);
    chk("R8 partial data", int'(rx_data), 'h001);
    chk("R8 rdf", int'(rdf), 1);
    chk("R8 fe", int'(fe), 1);
    chk("R8 pe", int'(pe), 1);
    chk("R8 brk not yet", int'(brk), 0);
    drive(1'b0, 3 * BT);
    chk("R8 brk after run", int'(brk), 1);
    drive(1'b1, 2 * BT);
    pulse_clr(4'b1111);
    par_en = 1'b0; brk_en = 1'b0;

    // set beats clear in the same cycle
    clr_rdf = 1'b1; seen = 0; mon_en = 1;
    send_frame(9'h077, 8);
    mon_en = 0; clr_rdf = 1'b0;
    chk("R11 set wins over clear", int'(seen), 1);
    @(negedge clk);
    chk("R11 cleared afterwards", int'(rdf), 0);
    chk("R3 data 0x77", int'(rx_data), 'h077);

    drive(1'b1, BT);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule